// File: doc/BRIEF.md
# Three-Wire Mode Register Port

The block receives write-only control frames on a three-wire serial port and uses them to load the mode register file of an eight-channel audio converter. The pins are a frame-select line (`sel_n`, active low), a serial bit clock (`sclk`) and a serial data line (`sdat`). All three are oversampled in the system clock domain. Each frame is 16 bits long. It carries a write flag, a 7-bit register index and 8 data bits.

The block holds the register bank and applies the reset defaults. It drives every decoded control field out in parallel to the converter datapath. A frame only takes effect when the select line rises after exactly sixteen bit clocks. Frames to undefined indices are dropped. A few channel bits live in two registers, and their effective value is the OR of the two copies. A self-clearing soft-reset bit reloads every default and holds the bank at those defaults for a fixed number of system clocks. The port ignores all traffic until an external power-on-done input is asserted.

Top module: `ctrl_port3w`

## Requirements
- R1: A frame starts on the falling edge of `sel_n`. `sdat` is sampled on each rising edge of `sclk` while `sel_n` is low, with the most significant bit first.
- R2: In a 16-bit frame, bit 15 is the write flag and must be 0. Bits 14:8 are the register index and bits 7:0 are the data.
- R3: The data reaches the indexed register only on the rising edge of `sel_n`. A frame that has clocked 16 bits but still has `sel_n` low changes no output.
- R4: Frames addressed to index 0, 14, 15 or any index from 20 to 127 change no output. Only indices 1–13 and 16–19 are written.
- R5: A frame is discarded when `sel_n` rises if it carried a bit count other than 16 or had bit 15 set.
- R6: After `rst_n`, the outputs take these values: every attenuation byte is 0xFF, `fmt_o` is 4'b0101, `chan_inv_o` is 8'hFF, `grp_slow_o` is 4'hF, and every other output is 0.
- R7: A committed frame to index 10 with data bit 7 set reloads every default at once. The bank then stays at defaults and ignores frames for SRST_CLKS system clocks (1024 by default). After that, frames are accepted again.
- R8: `mute_o[6]` is register 7 bit 6 OR register 18 bit 0, and `mute_o[7]` is register 7 bit 7 OR register 18 bit 1. `dac_off_o[7:6]` is built the same way from register 8 bits 7:6 and register 19 bits 1:0.
- R9: While `por_done` is low, no frame changes any output.
- R10: Field map:
  - Attenuation for channel k (1–8) sits in `atten_o[8k-1:8k-8]`. Its register is k for channels 1–6, 16 for channel 7 and 17 for channel 8.
  - Register 7 bits 7:0 drive `mute_o[7:0]`, and register 8 bits 7:0 drive `dac_off_o[7:0]`.
  - Register 9 drives `fmt_o` from bits 3:0 and `slow_roll_o` from bit 5.
  - Register 10 drives `deemph_on_o` from bit 0, `deemph_fs_o` from bits 4:3, `phase_inv_o` from bit 5 and `zflag_inv_o` from bit 6.
  - Register 11 drives `chan_inv_o`.
  - Register 12 drives `grp_slow_o` from bits 3:0 and `wide_os_o` from bit 7.
  - Register 13 drives `zflag_map_o` from bits 6:5 and `atten_coarse_o` from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_done | input | 1 | Power-on sequence finished; the port is live when high |
| sel_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial bit clock |
| sdat | input | 1 | Serial data, MSB first |
| atten_o | output | 64 | Eight attenuation bytes, channel 1 in the low byte |
| mute_o | output | 8 | Per-channel soft-mute request |
| dac_off_o | output | 8 | Per-channel converter disable |
| fmt_o | output | 4 | Audio data format code |
| slow_roll_o | output | 1 | Slow filter roll-off for all channels |
| deemph_on_o | output | 1 | De-emphasis enable |
| deemph_fs_o | output | 2 | De-emphasis sample-rate select |
| phase_inv_o | output | 1 | Global output phase invert |
| zflag_inv_o | output | 1 | Zero-flag polarity invert |
| chan_inv_o | output | 8 | Per-channel phase select |
| wide_os_o | output | 1 | Wide oversampling mode |
| grp_slow_o | output | 4 | Per-group filter roll-off select |
| atten_coarse_o | output | 1 | Coarse attenuation step mode |
| zflag_map_o | output | 2 | Zero-flag channel grouping select |

## Verification
The bench sends a frame that has clocked all sixteen bits but leaves the select line low, and checks that no output moves. A design that commits on the count alone would update early. Frames of 15 and 17 bits, frames with the write flag set, and frames to indices 0, 14, 15 and above 19 must all leave the outputs untouched; a loose index or count check would corrupt a neighbouring register. The bench sends a frame inside the soft-reset window and another one after it, which catches a reset that is too short or never ends. Mixed writes to the mirrored mute and disable bits expose a design that lets one copy overwrite the other instead of ORing them.

// File: rtl/ctrl_port3w.sv
module ctrl_port3w #(
  parameter int SRST_CLKS   = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_done,
  input  logic        sel_n,
  input  logic        sclk,
  input  logic        sdat,
  output logic [63:0] atten_o,
  output logic [7:0]  mute_o,
  output logic [7:0]  dac_off_o,
  output logic [3:0]  fmt_o,
  output logic        slow_roll_o,
  output logic        deemph_on_o,
  output logic [1:0]  deemph_fs_o,
  output logic        phase_inv_o,
  output logic        zflag_inv_o,
  output logic [7:0]  chan_inv_o,
  output logic        wide_os_o,
  output logic [3:0]  grp_slow_o,
  output logic        atten_coarse_o,
  output logic [1:0]  zflag_map_o
);
  localparam int FRAME_BITS = 16;
  localparam int CW         = $clog2(FRAME_BITS + 2);
  localparam int RW         = $clog2(SRST_CLKS + 1);
  localparam logic [CW-1:0] CNT_IDLE = CW'(FRAME_BITS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);

  function automatic logic [7:0] dflt(input int i);
    case (i)
      1, 2, 3, 4, 5, 6, 16, 17, 11: dflt = 8'hFF;
      9:                             dflt = 8'h05;
      12:                            dflt = 8'h0F;
      default:                       dflt = 8'h00;
    endcase
  endfunction

  logic [SYNC_STAGES-1:0] ms_s, mc_s, md_s;
  logic ms_d, mc_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ms_s <= '1; mc_s <= '0; md_s <= '0;
      ms_d <= 1'b1; mc_d <= 1'b0;
    end else begin
      ms_s <= {ms_s[SYNC_STAGES-2:0], sel_n};
      mc_s <= {mc_s[SYNC_STAGES-2:0], sclk};
      md_s <= {md_s[SYNC_STAGES-2:0], sdat};
      ms_d <= ms_s[SYNC_STAGES-1];
      mc_d <= mc_s[SYNC_STAGES-1];
    end

  wire ms      = ms_s[SYNC_STAGES-1];
  wire mc      = mc_s[SYNC_STAGES-1];
  wire md      = md_s[SYNC_STAGES-1];
  wire mc_rise = mc & ~mc_d;
  wire ms_fall = ~ms & ms_d;
  wire ms_rise = ms & ~ms_d;

  logic [15:0]   shift_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= CNT_IDLE;
    end else if (ms_fall) begin
      cnt_q <= '0;
    end else if (ms_rise) begin
      cnt_q <= CNT_IDLE;
    end else if (!ms && mc_rise) begin
      shift_q <= {shift_q[14:0], md};
      if (cnt_q != CNT_IDLE) cnt_q <= cnt_q + 1'b1;
    end

  wire [6:0] idx = shift_q[14:8];
  wire [7:0] dat = shift_q[7:0];
  wire writable = (idx >= 7'd1 && idx <= 7'd13) || (idx >= 7'd16 && idx <= 7'd19);

  logic [RW-1:0] rcnt_q;
  wire busy   = (rcnt_q != '0);
  wire commit = ms_rise && (cnt_q == CNT_FULL) && !shift_q[15] && por_done && !busy && writable;
  wire srst   = commit && (idx == 7'd10) && dat[7];

  logic [7:0] rf [1:19];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 1; i <= 19; i++) rf[i] <= dflt(i);
    end else if (busy || srst) begin
      for (int i = 1; i <= 19; i++) rf[i] <= dflt(i);
    end else if (commit) begin
      rf[idx[4:0]] <= dat;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rcnt_q <= '0;
    else if (srst)  rcnt_q <= RW'(SRST_CLKS);
    else if (busy)  rcnt_q <= rcnt_q - 1'b1;

  assign atten_o        = {rf[17], rf[16], rf[6], rf[5], rf[4], rf[3], rf[2], rf[1]};
  assign mute_o         = {rf[7][7] | rf[18][1], rf[7][6] | rf[18][0], rf[7][5:0]};
  assign dac_off_o      = {rf[8][7] | rf[19][1], rf[8][6] | rf[19][0], rf[8][5:0]};
  assign fmt_o          = rf[9][3:0];
  assign slow_roll_o    = rf[9][5];
  assign deemph_on_o    = rf[10][0];
  assign deemph_fs_o    = rf[10][4:3];
  assign phase_inv_o    = rf[10][5];
  assign zflag_inv_o    = rf[10][6];
  assign chan_inv_o     = rf[11];
  assign wide_os_o      = rf[12][7];
  assign grp_slow_o     = rf[12][3:0];
  assign atten_coarse_o = rf[13][7];
  assign zflag_map_o    = rf[13][6:5];

  wire unused_bits = ^{rf[9][7:6], rf[9][4], rf[10][7], rf[10][2:1], rf[12][6:4],
                       rf[13][4:0], rf[14], rf[15], rf[18][7:2], rf[19][7:2]};

  wire [105:0] cfg_bus = {atten_o, mute_o, dac_off_o, fmt_o, slow_roll_o, deemph_on_o,
                          deemph_fs_o, phase_inv_o, zflag_inv_o, chan_inv_o, wide_os_o,
                          grp_slow_o, atten_coarse_o, zflag_map_o};

  // R1
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_fall |=> cnt_q == '0);
  // R3
  hold_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_rise && !busy) |=> $stable(cfg_bus));
  // R5
  bad_count_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_rise && cnt_q != CNT_FULL) |=> $stable(cfg_bus));
  // R9
  por_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_done && !busy) |=> $stable(cfg_bus));
  // R7
  srst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (atten_o == '1 && chan_inv_o == '1 && mute_o == '0 && fmt_o == 4'b0101));
endmodule

// File: tb/ctrl_port3w_tb_top.sv
module ctrl_port3w_tb_top;
  logic clk = 0, rst_n = 0, por_done = 0, sel_n = 1, sclk = 0, sdat = 0;
  logic [63:0] atten_o; logic [7:0] mute_o, dac_off_o, chan_inv_o;
  logic [3:0] fmt_o, grp_slow_o; logic [1:0] deemph_fs_o, zflag_map_o;
  logic slow_roll_o, deemph_on_o, phase_inv_o, zflag_inv_o, wide_os_o, atten_coarse_o;

  always #4 clk = ~clk;

  ctrl_port3w dut_i (.*);

  int total = 0, fails = 0;
  logic [7:0] mdl [1:19];
  bit live = 0;

  function automatic logic [7:0] dflt(input int i);
    if ((i >= 1 && i <= 6) || i == 16 || i == 17 || i == 11) return 8'hFF;
    if (i == 9) return 8'h05;
    if (i == 12) return 8'h0F;
    return 8'h00;
  endfunction

  task automatic load_defaults();
    for (int i = 1; i <= 19; i++) mdl[i] = dflt(i);
  endtask

  function automatic logic [105:0] exp_bus();
    logic [7:0] mu, dc;
    mu = {mdl[7][7] | mdl[18][1], mdl[7][6] | mdl[18][0], mdl[7][5:0]};
    dc = {mdl[8][7] | mdl[19][1], mdl[8][6] | mdl[19][0], mdl[8][5:0]};
    return {mdl[17], mdl[16], mdl[6], mdl[5], mdl[4], mdl[3], mdl[2], mdl[1], mu, dc,
            mdl[9][3:0], mdl[9][5], mdl[10][0], mdl[10][4:3], mdl[10][5], mdl[10][6],
            mdl[11], mdl[12][7], mdl[12][3:0], mdl[13][7], mdl[13][6:5]};
  endfunction

  function automatic logic [105:0] act_bus();
    return {atten_o, mute_o, dac_off_o, fmt_o, slow_roll_o, deemph_on_o, deemph_fs_o,
            phase_inv_o, zflag_inv_o, chan_inv_o, wide_os_o, grp_slow_o, atten_coarse_o,
            zflag_map_o};
  endfunction

  task automatic chk(input string req);
    logic [105:0] a, e;
    a = act_bus(); e = exp_bus();
    total++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, a, e);
    end
  endtask

  task automatic model_apply(input logic [15:0] w, input int nbits);
    int ix = int'(w[14:8]);
    if (!live || nbits != 16 || w[15]) return;
    if (!((ix >= 1 && ix <= 13) || (ix >= 16 && ix <= 19))) return;
    if (ix == 10 && w[7]) load_defaults();
    else mdl[ix] = w[7:0];
  endtask

  task automatic raise_sel();
    sel_n = 1; repeat (8) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits, input bit hold);
    @(negedge clk); sel_n = 0; repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdat = (i < 16) ? w[15-i] : 1'b0;
      repeat (4) @(negedge clk); sclk = 1;
      repeat (4) @(negedge clk); sclk = 0;
    end
    repeat (4) @(negedge clk);
    if (!hold) raise_sel();
  endtask

  task automatic wr(input logic [6:0] ix, input logic [7:0] d, input string req);
    send_frame({1'b0, ix, d}, 16, 0);
    model_apply({1'b0, ix, d}, 16);
    chk(req);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int nb, pick;
    void'($urandom(32'h5EED_0042));
    load_defaults();
    repeat (5) @(negedge clk); rst_n = 1; repeat (4) @(negedge clk);
    chk("R6 reset defaults");

    // R9 port dead before power-on done
    send_frame({1'b0, 7'd1, 8'h11}, 16, 0); chk("R9 write before por_done");
    por_done = 1; live = 1; repeat (2) @(negedge clk);

    // R1 R2 R10 directed
    wr(7'd1, 8'hA5, "R1 R2 atten ch1 MSB first");
    wr(7'd17, 8'h3C, "R10 atten ch8 via reg 17");
    wr(7'd10, 8'h79, "R10 reg 10 fields");

    // R3 no commit before select rises
    send_frame({1'b0, 7'd2, 8'h33}, 16, 1); chk("R3 held select no commit");
    raise_sel(); model_apply({1'b0, 7'd2, 8'h33}, 16); chk("R3 commit on rise");

    // R4 undefined indices
    wr(7'd0, 8'h00, "R4 index 0 ignored");
    wr(7'd14, 8'h55, "R4 index 14 ignored");
    wr(7'd15, 8'hAA, "R4 index 15 ignored");
    wr(7'd20, 8'h00, "R4 index 20 ignored");
    wr(7'd127, 8'h00, "R4 index 127 ignored");

    // R5 bad frames
    send_frame({1'b1, 7'd3, 8'h00}, 16, 0); chk("R5 write flag set");
    send_frame({1'b0, 7'd3, 8'h00}, 15, 0); chk("R5 15-bit frame");
    send_frame({1'b0, 7'd3, 8'h00}, 17, 0); chk("R5 17-bit frame");

    // R8 mirrored bits
    wr(7'd7, 8'h40, "R8 mute ch7 from reg 7");
    wr(7'd18, 8'h02, "R8 mute ch8 from reg 18 OR");
    wr(7'd7, 8'h00, "R8 mute ch8 stays via reg 18");
    wr(7'd19, 8'h01, "R8 dac ch7 from reg 19");
    wr(7'd8, 8'h80, "R8 dac ch8 from reg 8 with reg 19");

    // R7 soft reset
    wr(7'd10, 8'h80, "R7 soft reset reloads defaults");
    send_frame({1'b0, 7'd1, 8'h12}, 16, 0); chk("R7 frame ignored during reset");
    repeat (1100) @(negedge clk);
    wr(7'd1, 8'h12, "R7 frame accepted after reset window");

    // random traffic
    for (int n = 0; n < 70; n++) begin
      pick = $urandom_range(0, 19);
      w = 16'($urandom());
      if (pick < 13) w[14:8] = 7'(pick + 1);
      else if (pick < 17) w[14:8] = 7'(pick + 3);
      if (w[14:8] == 7'd10) w[7] = 1'b0;
      w[15] = ($urandom_range(0, 9) == 0);
      nb = ($urandom_range(0, 9) == 0) ? 15 + 2 * $urandom_range(0, 1) : 16;
      send_frame(w, nb, 0);
      model_apply(w, nb);
      chk("R2 R4 R5 R8 R10 random frame");
    end

    done = 1;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule